// File: doc/BRIEF.md
# Multi-Block Erase Address Collector

This block gathers the set of memory blocks that one block-erase command will clear. A start pulse, given on the confirming write of the two-write command, captures the first block from the upper address bits and opens a loading phase. Each further write strobe during that phase marks one more block in a flag register. Loading closes in one of two ways. Either a quiet window of a set number of microsecond ticks passes with no new write, or a cap on the whole loading phase is reached. The block then emits a one-cycle erase-start pulse and holds the flag vector steady until the erase engine reports completion.

Two decode modes exist. In the uniform mode every block is 16 KB and the three top address bits choose one of eight flags. In the mixed mode the top 16 KB region is split into four 4 KB blocks, so there are seven large blocks and four small ones. All pins are plain control and status signals. Data does not stream through the block, so no valid/ready handshake or back-pressure applies. The mode is sampled once, on the start pulse.

Top module: `blk_erase_collector`

## Requirements
- R1: After reset, blk_flags_o is 0, busy_o is 0 and erase_start_o is 0.
- R2: A start_i pulse while idle sets blk_flags_o to exactly the decoded bit of blk_addr_i, raises busy_o from the next cycle and latches mode_i for the whole command.
- R3: In uniform mode (mode_i=0) the flag index equals blk_addr_i[4:2], giving indices 0 to 7.
- R4: In mixed mode (mode_i=1), if blk_addr_i[4:2] is not 7 the index is blk_addr_i[4:2]. If it is 7, the index is 7 + blk_addr_i[1:0], giving indices 7 to 10.
- R5: Each wr_i during loading sets the decoded flag and keeps all earlier flags. Writing a block that is already marked leaves the vector unchanged and raises no error.
- R6: Loading closes on the WIN_TICKS-th tick_i counted since the last write, or since the start if there has been no write. Any write restarts that count. erase_start_o is high in the cycle after the closing tick.
- R7: Loading also closes on the LOAD_TICKS-th tick_i counted since the start, even while writes keep arriving.
- R8: erase_start_o is high for exactly one clock per command.
- R9: After loading closes, blk_flags_o stays stable and busy_o stays high until erase_done_i. During that time wr_i and start_i have no effect.
- R10: erase_done_i while erasing returns the block to idle, and busy_o falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = uniform 16 KB blocks, 1 = mixed 16 KB / 4 KB blocks |
| start_i | input | 1 | Confirming-write pulse; carries the first block address |
| wr_i | input | 1 | End-of-write strobe for each further block load |
| blk_addr_i | input | 5 | Address bits 16..12 |
| tick_i | input | 1 | One-cycle microsecond tick |
| erase_done_i | input | 1 | Erase engine has finished |
| blk_flags_o | output | 11 | Flags of the blocks to erase |
| erase_start_o | output | 1 | One-cycle launch pulse |
| busy_o | output | 1 | Loading or erasing |

## Verification
Every one of the 32 upper-address values is loaded alone in both modes. This separates the uniform and mixed decodes, and it checks that the four small blocks and the top large block map to distinct flags. Each single-block run also times the quiet window tick by tick, so closing one tick early or late is caught. Multi-write runs mark every uniform block, repeat a block, and keep writing every few ticks. These runs tell window expiry apart from the overall cap, and show that writes restart the window. Writes and starts issued while erasing confirm that the latched vector is frozen.

// File: rtl/blkcol_pkg.sv
package blkcol_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ERASE} col_state_e;
  localparam int UPPER_W   = 5;                    // address bits 16..12
  localparam int BIG_CODES = 8;                    // codes of bits 16..14
  localparam int SMALL_CNT = 4;                    // 4 KB blocks in top region
  localparam int FLAG_W    = BIG_CODES - 1 + SMALL_CNT;
endpackage

// File: rtl/blkcol_decode.sv
module blkcol_decode
  import blkcol_pkg::*;
(
  input  logic               mixed_i,
  input  logic [UPPER_W-1:0] addr_i,
  output logic [FLAG_W-1:0]  hit_o
);
  logic top_region;
  assign top_region = (addr_i[UPPER_W-1 -: 3] == 3'd7);

  for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
    if (g < BIG_CODES - 1) begin : g_big
      assign hit_o[g] = (addr_i[UPPER_W-1 -: 3] == 3'(g));
    end else if (g == BIG_CODES - 1) begin : g_edge
      // uniform: whole top 16 KB; mixed: first 4 KB sub-block
      assign hit_o[g] = top_region && (!mixed_i || addr_i[1:0] == 2'd0);
    end else begin : g_small
      assign hit_o[g] = mixed_i && top_region && (addr_i[1:0] == 2'(g - (BIG_CODES - 1)));
    end
  end
endmodule

// File: rtl/blkcol_timer.sv
module blkcol_timer #(
  parameter int WIN_TICKS  = 30,
  parameter int LOAD_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic wr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int GW = $clog2(WIN_TICKS + 1);
  localparam int TW = $clog2(LOAD_TICKS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(WIN_TICKS - 1);
  localparam logic [TW-1:0] TOT_LAST = TW'(LOAD_TICKS - 1);

  logic [GW-1:0] gap_q;
  logic [TW-1:0] tot_q;

  assign expire_o = run_i && tick_i &&
                    ((gap_q == GAP_LAST && !wr_i) || tot_q == TOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      tot_q <= '0;
    end else if (clear_i) begin
      gap_q <= '0;
      tot_q <= '0;
    end else if (run_i) begin
      if (wr_i)        gap_q <= '0;
      else if (tick_i) gap_q <= gap_q + 1'b1;
      if (tick_i)      tot_q <= tot_q + 1'b1;
    end
  end

  a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (gap_q <= GAP_LAST));
  a_r7_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (tot_q <= TOT_LAST));
endmodule

// File: rtl/blk_erase_collector.sv
module blk_erase_collector
  import blkcol_pkg::*;
#(
  parameter int WIN_TICKS  = 30,
  parameter int LOAD_TICKS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [4:0]        blk_addr_i,
  input  logic              tick_i,
  input  logic              erase_done_i,
  output logic [10:0]       blk_flags_o,
  output logic              erase_start_o,
  output logic              busy_o
);
  col_state_e         state_q;
  logic               mode_q;
  logic [FLAG_W-1:0]  flags_q;
  logic [FLAG_W-1:0]  hit;
  logic               go_q;
  logic               expire;
  logic               dec_mode;

  assign dec_mode = (state_q == ST_IDLE) ? mode_i : mode_q;

  blkcol_decode u_dec (
    .mixed_i (dec_mode),
    .addr_i  (blk_addr_i),
    .hit_o   (hit)
  );

  blkcol_timer #(.WIN_TICKS(WIN_TICKS), .LOAD_TICKS(LOAD_TICKS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (state_q == ST_IDLE && start_i),
    .run_i    (state_q == ST_LOAD),
    .wr_i     (wr_i),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      flags_q <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          flags_q <= hit;
          mode_q  <= mode_i;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          if (wr_i) flags_q <= flags_q | hit;
          if (expire) begin
            state_q <= ST_ERASE;
            go_q    <= 1'b1;
          end
        end
        ST_ERASE: if (erase_done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign blk_flags_o   = flags_q;
  assign erase_start_o = go_q;
  assign busy_o        = (state_q != ST_IDLE);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |=> !erase_start_o);
  a_r2_busy_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (blk_flags_o != '0));
  a_r5_flags_only_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |=> ((blk_flags_o & $past(blk_flags_o)) == $past(blk_flags_o)));
  a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && !erase_done_i) |=> ($stable(blk_flags_o) && busy_o));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERASE && erase_done_i) |=> !busy_o);
  a_r3_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(hit));
endmodule

// File: tb/test_blk_erase_collector.sv
module test_blk_erase_collector;
  localparam int WIN  = 4;
  localparam int LOAD = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, start = 1'b0, wr = 1'b0, tick = 1'b0, done = 1'b0;
  logic [4:0] addr = '0;
  logic [10:0] flags;
  logic go, busy;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  blk_erase_collector #(.WIN_TICKS(WIN), .LOAD_TICKS(LOAD)) i_blk_erase_collector (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .start_i(start), .wr_i(wr),
    .blk_addr_i(addr), .tick_i(tick), .erase_done_i(done),
    .blk_flags_o(flags), .erase_start_o(go), .busy_o(busy)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic t, input logic d,
                      input logic [4:0] a);
    start = s; wr = w; tick = t; done = d; addr = a;
    @(negedge clk);
    start = 0; wr = 0; tick = 0; done = 0;
  endtask

  function automatic int idx_of(input logic m, input logic [4:0] a);
    if (a[4:2] != 3'd7) return int'(a[4:2]);
    if (!m) return 7;
    return 7 + int'(a[1:0]);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [10:0] expf;
    repeat (3) @(negedge clk);
    chk(flags == 0 && !busy && !go, "R1 reset", {flags, busy, go}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // single-block sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 32; a++) begin
        mode = m[0];
        expf = 11'(1) << idx_of(m[0], 5'(a));
        step(1, 0, 0, 0, 5'(a));
        mode = ~m[0];  // latched mode must persist
        chk(busy && flags == expf, m ? "R4 mixed decode" : "R3 uniform decode", flags, expf);
        for (int k = 1; k < WIN; k++) begin
          step(0, 0, 1, 0, 0);
          chk(!go, "R6 no early close", go, 0);
        end
        step(0, 0, 1, 0, 0);
        chk(go && flags == expf, "R6 close on window", {go, flags}, {1'b1, expf});
        step(0, 1, 0, 0, 5'(a ^ 5'h1C));
        chk(!go, "R8 pulse one cycle", go, 0);
        chk(flags == expf && busy, "R9 write ignored while erasing", flags, expf);
        step(1, 0, 0, 0, 5'(a ^ 5'h10));
        chk(flags == expf && busy, "R9 start ignored while erasing", flags, expf);
        step(0, 0, 0, 1, 0);
        chk(!busy, "R10 done to idle", busy, 0);
      end
    end

    // all eight uniform blocks, with a duplicate
    mode = 0;
    step(1, 0, 0, 0, 5'd0);
    for (int b = 1; b < 8; b++) begin
      step(0, 1, 0, 0, 5'(b << 2));
      chk(flags == 11'((1 << (b + 1)) - 1), "R5 accumulate", flags, (1 << (b + 1)) - 1);
    end
    step(0, 1, 0, 0, 5'd8);
    chk(flags == 11'hFF, "R5 duplicate", flags, 11'hFF);

    // window restart by write
    for (int k = 1; k < WIN; k++) step(0, 0, 1, 0, 0);
    step(0, 1, 0, 0, 5'd4);
    for (int k = 1; k < WIN; k++) begin
      step(0, 0, 1, 0, 0);
      chk(!go, "R6 write restarts window", go, 0);
    end
    step(0, 0, 1, 0, 0);
    chk(go && busy, "R6 close after restart", go, 1);
    step(0, 0, 0, 1, 0);

    // overall cap: writes every three ticks keep window open
    step(1, 0, 0, 0, 5'd12);
    for (int t = 1; t <= LOAD; t++) begin
      step(0, 0, 1, 0, 0);
      if (t < LOAD) chk(!go, "R7 open before cap", go, 0);
      else          chk(go, "R7 close at cap", go, 1);
      if (t % 3 == 0 && t < LOAD) step(0, 1, 0, 0, 5'((t / 3 - 1) << 2));
    end
    chk(flags == 11'h0F, "R7 flags at cap", flags, 11'h0F);
    step(0, 0, 0, 0, 0);
    chk(!go && busy, "R8 single pulse at cap", go, 0);
    step(0, 0, 0, 1, 0);
    chk(!busy, "R10 done", busy, 0);

    // mixed mode small blocks together
    mode = 1;
    step(1, 0, 0, 0, 5'h1C);
    for (int s = 1; s < 4; s++) step(0, 1, 0, 0, 5'(5'h1C + s));
    chk(flags == 11'h780, "R4 four small blocks", flags, 11'h780);
    for (int k = 0; k < WIN; k++) step(0, 0, 1, 0, 0);
    chk(go, "R6 mixed close", go, 1);
    step(0, 0, 0, 1, 0);
    finish_run();
  end
endmodule